// File: doc/BRIEF.md
# Variable Pulse Width Bus Frame Decoder

This block sits behind the receive comparator of a single-wire variable-pulse-width vehicle bus. It takes the digitized bus level together with a one-microsecond tick. It measures the width of every high and low segment and sorts each segment into one of three classes: a short or long data symbol, a delimiter, or an unusable width. It then walks the frame sequence. The sequence runs from start of frame, through the data bytes ending in a check byte and the end-of-data gap, to the normalization pulse, any in-frame response bytes and the end-of-frame gap.

Received bytes leave through a valid/ready stream. The block has one holding register and no other buffering. Once `m_valid` is high, `m_data` and `m_resp` stay unchanged until a cycle with `m_ready` high takes them. Bytes arrive no closer together than eight data symbols, so a sink that answers within that time never loses one. If a byte completes while the previous one is still waiting, the new byte is dropped and `ovr_err` pulses. Frame events are reported as one-cycle pulses. A frame that breaks the sequence is abandoned, and the decoder waits for the next start of frame. All widths and the byte limit are parameters, counted in ticks.

Top module: `vpw_frame_decoder`

## Requirements
- R1: After reset, all outputs are low and the decoder waits for a start of frame.
- R2: While waiting, only a high segment of 180 to 220 ticks is accepted as a start of frame. It gives a one-cycle `frm_start`. Any other segment seen while waiting is ignored, with no error.
- R3: A short segment is 44 to 84 ticks and a long segment is 108 to 148 ticks. A low short segment is bit 1, a low long segment is bit 0, a high short segment is bit 0, and a high long segment is bit 1.
- R4: Bits are assembled most significant first. Each completed byte is offered on `m_data`, with `m_resp` low for bytes sent before the end-of-data gap.
- R5: A pending byte keeps `m_valid` high, and its data does not change, until `m_ready` is high. A byte that completes while one is still pending is discarded, and `ovr_err` pulses for one cycle.
- R6: The check is made when the data part closes, either at the end-of-data gap or at the end-of-frame gap. The last byte before that point must equal the inverted CRC of all the data bytes before it. That CRC uses polynomial 0x1D, starts from 0xFF and is fed most significant bit first. If the last byte does not match, `crc_bad` pulses for one cycle.
- R7: A low segment of 180 to 220 ticks at a byte boundary, after at least one byte, ends the data part. The high segment that follows must be short or long. A long segment sets `resp_crc` to 1 and a short one sets it to 0; `resp_crc` keeps that value until the next start of frame. `resp_phase` is high while response bytes are being received, and those bytes carry `m_resp` high.
- R8: A low level that lasts 260 ticks at a byte boundary, in the data part (after at least one byte) or the response part, ends the frame. It gives a one-cycle `frm_end`, and the decoder returns to waiting.
- R9: A frame may carry at most 12 bytes in total, data and response together. A 13th byte is not emitted; it gives `frm_err` and abandons the frame.
- R10: Inside a frame, any of the following gives a one-cycle `frm_err` and a return to waiting: a segment that fits no width window, a delimiter in the wrong place, or a gap in the middle of a byte. The next start of frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| bus_in | input | 1 | Digitized bus level, asynchronous |
| m_ready | input | 1 | Sink accepts the pending byte |
| m_valid | output | 1 | A received byte is pending |
| m_data | output | 8 | Received byte |
| m_resp | output | 1 | Byte belongs to the in-frame response |
| frm_start | output | 1 | Start of frame accepted (pulse) |
| frm_end | output | 1 | End of frame reached (pulse) |
| frm_err | output | 1 | Framing error, frame abandoned (pulse) |
| crc_bad | output | 1 | Data check byte mismatch (pulse) |
| ovr_err | output | 1 | Byte dropped, sink too slow (pulse) |
| resp_phase | output | 1 | Receiving in-frame response bytes |
| resp_crc | output | 1 | Last normalization pulse was long |

## Verification
A wrong bit count or a wrong level sense shows up on the very next byte at `m_data`, no later than eight symbols after the fault. A stale sequence state shows up differently: as an `frm_err` where a clean `frm_end` is due, or as a `frm_start` that is missing, within one gap of 260 ticks. A wrong CRC register only shows at the close of the data part, as a `crc_bad` that either appears or fails to appear. For that reason, frames are sent both with good and with corrupted check bytes. Bytes and pulses are gathered over each whole frame and then compared with what the bench expects. The stream rule is tested by holding `m_ready` low across a frame.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  // width class of one measured bus segment
  typedef enum logic [1:0] {
    W_SHORT = 2'd0,
    W_LONG  = 2'd1,
    W_DELIM = 2'd2,
    W_BAD   = 2'd3
  } wclass_t;

  // frame walker position
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_NORM = 2'd2,
    ST_RESP = 2'd3
  } fstate_t;

  // one byte through the 8-bit check register, polynomial 0x1D, MSB first
  function automatic logic [7:0] crc8_byte(input logic [7:0] cur, input logic [7:0] din);
    logic [7:0] r;
    r = cur;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ din[i]) r = {r[6:0], 1'b0} ^ 8'h1D;
      else               r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/vpw_edge_timer.sv
module vpw_edge_timer #(
  parameter int CNT_W   = 10,
  parameter int EOF_MIN = 260
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_in,
  output logic             seg_done,
  output logic             seg_level,
  output logic [CNT_W-1:0] seg_width,
  output logic             eof_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] EOF_PRE = CNT_W'(EOF_MIN - 1);

  logic             sync_a, sync_b, lvl_q;
  logic [CNT_W-1:0] cnt;
  logic             edge_w;

  assign edge_w = sync_b ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      lvl_q  <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_a <= bus_in;
      sync_b <= sync_a;
      lvl_q  <= sync_b;
      if (edge_w)                    cnt <= tick ? CNT_W'(1) : '0;
      else if (tick && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end
  end

  assign seg_done  = edge_w;
  assign seg_level = lvl_q;
  assign seg_width = cnt;
  assign eof_hit   = tick && !edge_w && !lvl_q && (cnt == EOF_PRE);

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> (cnt <= CNT_W'(1)));  // R3

endmodule

// File: rtl/vpw_width_class.sv
module vpw_width_class
  import vpw_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int T_SHORT = 64,
  parameter int T_LONG  = 128,
  parameter int T_SOF   = 200,
  parameter int T_EOD   = 200,
  parameter int T_TOL   = 20
) (
  input  logic             level,
  input  logic [CNT_W-1:0] width,
  output wclass_t          cls,
  output logic             bit_val
);
  function automatic logic in_win(input int w, input int nom);
    return (w >= nom - T_TOL) && (w <= nom + T_TOL);
  endfunction

  int w_i;

  always_comb begin
    w_i = int'(width);
    if (in_win(w_i, T_SHORT))                 cls = W_SHORT;
    else if (in_win(w_i, T_LONG))             cls = W_LONG;
    else if (level && in_win(w_i, T_SOF))     cls = W_DELIM;
    else if (!level && in_win(w_i, T_EOD))    cls = W_DELIM;
    else                                      cls = W_BAD;
    // short symbol carries the opposite of its level, long carries the level
    bit_val = level ^ (cls == W_SHORT);
  end

endmodule

// File: rtl/vpw_frame_fsm.sv
module vpw_frame_fsm
  import vpw_pkg::*;
#(
  parameter int MAX_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seg_done,
  input  logic       seg_level,
  input  wclass_t    cls,
  input  logic       bit_val,
  input  logic       eof_hit,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       m_resp,
  output logic       frm_start,
  output logic       frm_end,
  output logic       frm_err,
  output logic       crc_bad,
  output logic       ovr_err,
  output logic       resp_phase,
  output logic       resp_crc
);
  localparam int BC_W = $clog2(MAX_BYTES + 1);
  localparam logic [BC_W-1:0] BC_LIM = BC_W'(MAX_BYTES);

  fstate_t         state;
  logic [7:0]      shreg, last_byte, crc, crc_prev;
  logic [2:0]      bitcnt;
  logic [BC_W-1:0] byte_cnt;

  logic [7:0] shift_nx;
  logic is_sym, is_bit, byte_done, over, emit, at_bound;
  logic do_start, do_err, do_norm, do_resp, do_end, do_check;

  always_comb begin
    shift_nx  = {shreg[6:0], bit_val};
    is_sym    = (cls == W_SHORT) || (cls == W_LONG);
    is_bit    = seg_done && is_sym && (state == ST_DATA || state == ST_RESP);
    byte_done = is_bit && (bitcnt == 3'd7);
    over      = byte_done && (byte_cnt == BC_LIM);
    emit      = byte_done && !over;
    at_bound  = (bitcnt == 3'd0) && (byte_cnt != '0);
    do_start = 1'b0; do_err = 1'b0; do_norm = 1'b0;
    do_resp  = 1'b0; do_end = 1'b0; do_check = 1'b0;
    case (state)
      ST_IDLE: do_start = seg_done && seg_level && (cls == W_DELIM);
      ST_DATA: begin
        if (seg_done) begin
          if (is_sym)                                do_err = over;
          else if (!seg_level && cls == W_DELIM && at_bound) begin
            do_norm = 1'b1; do_check = 1'b1;
          end else                                   do_err = 1'b1;
        end else if (eof_hit) begin
          if (at_bound) begin do_end = 1'b1; do_check = 1'b1; end
          else            do_err = 1'b1;
        end
      end
      ST_NORM: if (seg_done) begin
        if (seg_level && is_sym) do_resp = 1'b1;
        else                     do_err  = 1'b1;
      end
      default: begin
        if (seg_done) do_err = !is_sym || over;
        else if (eof_hit) begin
          if (bitcnt == 3'd0) do_end = 1'b1;
          else                do_err = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; shreg <= '0; last_byte <= '0; crc <= 8'hFF; crc_prev <= 8'hFF;
      bitcnt <= '0; byte_cnt <= '0; m_valid <= 1'b0; m_data <= '0; m_resp <= 1'b0;
      frm_start <= 1'b0; frm_end <= 1'b0; frm_err <= 1'b0; crc_bad <= 1'b0;
      ovr_err <= 1'b0; resp_crc <= 1'b0;
    end else begin
      frm_start <= do_start;
      frm_end   <= do_end;
      frm_err   <= do_err;
      crc_bad   <= do_check && (last_byte != ~crc_prev);
      ovr_err   <= emit && m_valid && !m_ready;
      if (do_start) begin
        state <= ST_DATA; bitcnt <= '0; byte_cnt <= '0;
        crc <= 8'hFF; crc_prev <= 8'hFF; resp_crc <= 1'b0;
      end
      if (is_bit && !do_err) begin
        shreg  <= shift_nx;
        bitcnt <= bitcnt + 3'd1;
      end
      if (emit) begin
        byte_cnt  <= byte_cnt + BC_W'(1);
        last_byte <= shift_nx;
        if (state == ST_DATA) begin
          crc_prev <= crc;
          crc      <= crc8_byte(crc, shift_nx);
        end
      end
      if (do_norm) state <= ST_NORM;
      if (do_resp) begin state <= ST_RESP; resp_crc <= (cls == W_LONG); end
      if (do_end || do_err) state <= ST_IDLE;
      // single holding register toward the sink
      if (emit && (!m_valid || m_ready)) begin
        m_valid <= 1'b1; m_data <= shift_nx; m_resp <= (state == ST_RESP);
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  assign resp_phase = (state == ST_RESP);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_resp)));  // R5
  AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= BC_LIM);  // R9
  AST_START_ENTERS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> (state == ST_DATA));  // R2
  AST_RESP_AFTER_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_phase) |-> ($past(state) == ST_NORM));  // R7
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> (state == ST_IDLE && !frm_err));  // R8
  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |-> (state == ST_IDLE));  // R10

endmodule

// File: rtl/vpw_frame_decoder.sv
module vpw_frame_decoder #(
  parameter int T_SHORT   = 64,
  parameter int T_LONG    = 128,
  parameter int T_SOF     = 200,
  parameter int T_EOD     = 200,
  parameter int T_EOF     = 280,
  parameter int T_TOL     = 20,
  parameter int MAX_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       bus_in,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       m_resp,
  output logic       frm_start,
  output logic       frm_end,
  output logic       frm_err,
  output logic       crc_bad,
  output logic       ovr_err,
  output logic       resp_phase,
  output logic       resp_crc
);
  localparam int EOF_MIN = T_EOF - T_TOL;
  localparam int CNT_W   = $clog2(T_EOF + T_TOL + 2) + 1;

  logic             seg_done, seg_level, eof_hit, bit_val;
  logic [CNT_W-1:0] seg_width;
  vpw_pkg::wclass_t cls;

  vpw_edge_timer #(.CNT_W(CNT_W), .EOF_MIN(EOF_MIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .bus_in(bus_in),
    .seg_done(seg_done), .seg_level(seg_level), .seg_width(seg_width), .eof_hit(eof_hit)
  );

  vpw_width_class #(
    .CNT_W(CNT_W), .T_SHORT(T_SHORT), .T_LONG(T_LONG),
    .T_SOF(T_SOF), .T_EOD(T_EOD), .T_TOL(T_TOL)
  ) u_class (
    .level(seg_level), .width(seg_width), .cls(cls), .bit_val(bit_val)
  );

  vpw_frame_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .seg_done(seg_done), .seg_level(seg_level),
    .cls(cls), .bit_val(bit_val), .eof_hit(eof_hit), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_resp(m_resp),
    .frm_start(frm_start), .frm_end(frm_end), .frm_err(frm_err),
    .crc_bad(crc_bad), .ovr_err(ovr_err), .resp_phase(resp_phase), .resp_crc(resp_crc)
  );

endmodule

// File: tb/sim_vpw_frame_decoder.sv
`timescale 1ns/1ps
module sim_vpw_frame_decoder;
  logic clk = 1'b0, rst_n = 1'b0, tick_us = 1'b1, bus_in = 1'b0, m_ready = 1'b1;
  logic m_valid, m_resp, frm_start, frm_end, frm_err, crc_bad, ovr_err, resp_phase, resp_crc;
  logic [7:0] m_data;

  vpw_frame_decoder u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_in(bus_in), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_resp(m_resp), .frm_start(frm_start),
    .frm_end(frm_end), .frm_err(frm_err), .crc_bad(crc_bad), .ovr_err(ovr_err),
    .resp_phase(resp_phase), .resp_crc(resp_crc)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int c_start = 0, c_end = 0, c_err = 0, c_crc = 0, c_ovr = 0;
  int rx_n = 0, ex_n = 0;
  logic [7:0] rx_b [16];
  logic       rx_r [16];
  logic [7:0] ex_b [16];
  logic       ex_r [16];

  // fields: count[37:34], bytes[33:2], corrupt[1], response[0]
  localparam int NV = 5;
  localparam logic [37:0] VEC [NV] = '{
    {4'd1, 32'h55000000, 1'b0, 1'b0},
    {4'd3, 32'h01020300, 1'b0, 1'b0},
    {4'd4, 32'hFF00A53C, 1'b0, 1'b0},
    {4'd2, 32'h12340000, 1'b1, 1'b0},
    {4'd2, 32'hC37E0000, 1'b0, 1'b1}
  };

  always @(negedge clk) begin
    if (frm_start) c_start++;
    if (frm_end)   c_end++;
    if (frm_err)   c_err++;
    if (crc_bad)   c_crc++;
    if (ovr_err)   c_ovr++;
    if (m_valid && m_ready && rx_n < 16) begin
      rx_b[rx_n] = m_data; rx_r[rx_n] = m_resp; rx_n++;
    end
  end

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic seg(input logic lv, input int w);
    bus_in = lv;
    repeat (w) @(negedge clk);
  endtask

  // a byte always starts on a low symbol and ends on a high one
  task automatic send_byte(input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      logic lv = k[0];
      logic bv = b[7-k];
      seg(lv, (bv != lv) ? 64 : 128);
    end
  endtask

  task automatic send_frame(input int n, input logic [31:0] bytes, input bit bad,
                            input bit rsp, input bit nb_long);
    logic [7:0] c = 8'hFF;
    logic [7:0] b;
    ex_n = 0; rx_n = 0;
    seg(1'b1, 200);
    for (int i = 0; i < n; i++) begin
      b = bytes[31-8*i -: 8];
      send_byte(b); c = ref_crc(c, b);
      ex_b[ex_n] = b; ex_r[ex_n] = 1'b0; ex_n++;
    end
    b = ~c ^ {7'd0, bad};
    send_byte(b); ex_b[ex_n] = b; ex_r[ex_n] = 1'b0; ex_n++;
    if (rsp) begin
      seg(1'b0, 200);
      seg(1'b1, nb_long ? 128 : 64);
      send_byte(8'h5A); ex_b[ex_n] = 8'h5A; ex_r[ex_n] = 1'b1; ex_n++;
    end
    seg(1'b0, 300);
  endtask

  task automatic cmp_bytes(input string req);
    int bad = 0;
    for (int i = 0; i < ex_n; i++)
      if (rx_b[i] !== ex_b[i] || rx_r[i] !== ex_r[i]) bad++;
    chk(rx_n == ex_n, req, rx_n, ex_n);
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #3_800_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    int s0, e0, r0, k0, o0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({m_valid, frm_start, frm_end, frm_err, crc_bad, ovr_err, resp_phase, resp_crc} == 8'h00,
        "R1 reset outputs", int'(m_valid), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R2: idle ignores non-start segments
    s0 = c_start; r0 = c_err;
    seg(1'b1, 64); seg(1'b0, 100); seg(1'b1, 300); seg(1'b0, 300);
    chk(c_start == s0, "R2 idle start ignored", c_start - s0, 0);
    chk(c_err == r0, "R2 idle no error", c_err - r0, 0);

    // table walk: R3 R4 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      s0 = c_start; e0 = c_end; r0 = c_err; k0 = c_crc;
      send_frame(int'(VEC[v][37:34]), VEC[v][33:2], VEC[v][1], VEC[v][0], 1'b1);
      chk(c_start - s0 == 1, "R2 start pulse", c_start - s0, 1);
      cmp_bytes("R3 R4 byte stream");
      chk(c_crc - k0 == int'(VEC[v][1]), "R6 check byte", c_crc - k0, int'(VEC[v][1]));
      chk(c_end - e0 == 1, "R8 end pulse", c_end - e0, 1);
      chk(c_err == r0, "R10 no framing error", c_err - r0, 0);
      if (VEC[v][0]) chk(resp_crc == 1'b1, "R7 long normalization", int'(resp_crc), 1);
    end

    // R7: short normalization pulse
    send_frame(1, 32'hA1000000, 1'b0, 1'b1, 1'b0);
    chk(resp_crc == 1'b0, "R7 short normalization", int'(resp_crc), 0);
    cmp_bytes("R7 response tagging");

    // R5: back-pressure, second byte dropped
    m_ready = 1'b0; o0 = c_ovr; e0 = c_end;
    send_frame(1, 32'h9A000000, 1'b0, 1'b0, 1'b0);
    chk(c_ovr - o0 == 1, "R5 overrun pulse", c_ovr - o0, 1);
    chk(m_valid == 1'b1 && m_data == 8'h9A, "R5 held byte", int'(m_data), 'h9A);
    chk(c_end - e0 == 1, "R8 end under back-pressure", c_end - e0, 1);
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_n == 1 && rx_b[0] == 8'h9A, "R5 accepted once", rx_n, 1);
    chk(m_valid == 1'b0, "R5 valid cleared", int'(m_valid), 0);

    // R9: thirteen bytes
    r0 = c_err; e0 = c_end; rx_n = 0;
    seg(1'b1, 200);
    for (int i = 0; i < 13; i++) send_byte(8'h11);
    seg(1'b0, 300);
    chk(c_err - r0 == 1, "R9 byte limit error", c_err - r0, 1);
    chk(rx_n == 12, "R9 twelve emitted", rx_n, 12);
    chk(c_end == e0, "R9 no end pulse", c_end - e0, 0);

    // R10: width outside every window
    r0 = c_err; e0 = c_end;
    seg(1'b1, 200); seg(1'b0, 100); seg(1'b1, 64); seg(1'b0, 300);
    chk(c_err - r0 == 1, "R10 bad width", c_err - r0, 1);
    chk(c_end == e0, "R10 no end after bad width", c_end - e0, 0);

    // R10: end-of-data gap in the middle of a byte
    r0 = c_err;
    seg(1'b1, 200); seg(1'b0, 64); seg(1'b1, 64); seg(1'b0, 64); seg(1'b1, 64);
    seg(1'b0, 200); seg(1'b1, 64); seg(1'b0, 300);
    chk(c_err - r0 == 1, "R10 gap mid byte", c_err - r0, 1);

    // R10: recovery on the next frame
    r0 = c_err; e0 = c_end;
    send_frame(2, 32'h6B2D0000, 1'b0, 1'b0, 1'b0);
    cmp_bytes("R10 recovery bytes");
    chk(c_end - e0 == 1 && c_err == r0, "R10 recovery end", c_end - e0, 1);

    finish_run();
  end

endmodule